// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a direct-mapped cache between a processor port that moves one 32-bit word and a memory port that moves one whole line of four words. Each line keeps a tag, a valid flag, a dirty flag and four data words. A read that hits returns the addressed word in the same cycle the request is presented. A processor write changes only the cached copy and marks the line dirty. Memory sees nothing until that line is evicted.

On a miss the processor is held off with a low ready. If the line being replaced is dirty, it is first written to memory at its own line address. The wanted line is then read in and installed clean. After that the original access completes as an ordinary hit. A write miss therefore refills the line before it merges the written word.

The processor keeps its request, address, write flag and write data steady until it sees ready. The line count is a parameter. The default uses 64 lines. Setting the index width to 12 gives 4096 lines, with a 16-bit tag in address bits 31:16 and the index in bits 15:4.

Top module: `dm_cache`

## Requirements
- R1: A byte address is decoded as follows. Bits 1:0 select the byte and are ignored. Bits 3:2 select the word within the line. The next IDX_W bits (default 6, so bits 9:4) are the line index. All bits above the index form the tag. The line index equals the block address (byte address divided by 16) modulo the number of lines.
- R2: Reset clears every valid flag and every dirty flag. After reset, every access misses, no replaced line is written back, and memReq and cpuReady are low while no request is pending.
- R3: A request is a hit only when the indexed line is valid and its stored tag equals the address tag. A line that has just been refilled hits on the cycle after memAck.
- R4: When a read hits, cpuReady is high in the same cycle the request is presented. cpuRdata then carries word N of the line, where N is address bits 3:2 and word N occupies line bits 32N+31:32N.
- R5: When a write hits, the addressed word and the dirty flag are updated at the clock edge where cpuReady is high. The other words are unchanged, and memory is neither read nor written.
- R6: A miss whose replaced line is invalid or clean produces exactly one line read (memWe low). The read uses the line-aligned address: the address tag and index with bits 3:0 zero. No write-back occurs.
- R7: A miss whose replaced line is valid and dirty first writes all 128 bits of that line to memory (memWe high). The write uses the stored tag and the index with bits 3:0 zero. Only after this write is acknowledged is the line read.
- R8: cpuReady stays low in every cycle in which memReq is high. A miss takes more than one cycle.
- R9: Once memReq is raised, memReq, memWe and memAddr hold steady until the cycle in which memAck is high. memAck completes a transfer in one cycle, and read data on memRline is taken in that same cycle.
- R10: A write miss fills the line from memory and then writes the processor word into it, leaving the line dirty. The other three words keep the values read from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | High for a write, low for a read |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Processor write word |
| cpuRdata | output | 32 | Word selected from the indexed line |
| cpuReady | output | 1 | Access completes at this clock edge |
| memReq | output | 1 | Line transfer request |
| memWe | output | 1 | High for a line write-back, low for a line read |
| memAddr | output | 32 | Line-aligned memory byte address |
| memWline | output | 128 | Line written back to memory |
| memAck | input | 1 | Memory completes the transfer this cycle |
| memRline | input | 128 | Line returned by memory, valid with memAck |

## Verification
Problems in the internal tag, valid or dirty state show up at the ports in one of two ways. One is a wrong count of line reads and writes on the memory port. The other is a word returned from the wrong line. A dirty flag that is lost only becomes visible on a later miss to the same index: the written word then fails to come back after a re-read from memory. For that reason the stimulus evicts dirty lines and reads them back. A stuck-valid or missing-refill fault appears within the same access, either as the wrong hit latency or as a wrong word.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic fillLine;   // install memRline, set valid, clear dirty
    logic writeWord;  // merge processor word, set dirty
    logic selVictim;  // memory address uses the stored tag
  } dpStrobe_t;
endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dpStrobe_t                strobe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [WORD_W-1:0]        cpuWdata,
  input  logic [WORDS*WORD_W-1:0]  memRline,
  output logic                     hit,
  output logic                     victimDirty,
  output logic [WORD_W-1:0]        rdWord,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [WORDS*WORD_W-1:0]  memWline
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int LINE_W = WORDS * WORD_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;

  logic [LINES-1:0] validBits;
  logic [LINES-1:0] dirtyBits;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINE_W-1:0] dataMem [LINES];

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [OFF_W-1:0]  reqOff;
  logic [TAG_W-1:0]  curTag;
  logic [LINE_W-1:0] curLine;
  logic [LINE_W-1:0] mergedLine;
  logic [WORD_W-1:0] lineWords [WORDS];

  assign reqTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx  = cpuAddr[BYTE_W+OFF_W +: IDX_W];
  assign reqOff  = cpuAddr[BYTE_W +: OFF_W];
  assign curTag  = tagMem[reqIdx];
  assign curLine = dataMem[reqIdx];

  assign hit         = validBits[reqIdx] && (curTag == reqTag);
  assign victimDirty = validBits[reqIdx] && dirtyBits[reqIdx];

  // block-offset word multiplexer
  for (genvar g = 0; g < WORDS; g++) begin : g_words
    assign lineWords[g] = curLine[g*WORD_W +: WORD_W];
  end
  assign rdWord = lineWords[reqOff];

  always_comb begin
    mergedLine = curLine;
    mergedLine[reqOff*WORD_W +: WORD_W] = cpuWdata;
  end

  assign memAddr  = {strobe.selVictim ? curTag : reqTag, reqIdx, {(OFF_W+BYTE_W){1'b0}}};
  assign memWline = curLine;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else if (strobe.fillLine) begin
      validBits[reqIdx] <= 1'b1;
      dirtyBits[reqIdx] <= 1'b0;
    end else if (strobe.writeWord) begin
      dirtyBits[reqIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillLine) begin
      tagMem[reqIdx]  <= reqTag;
      dataMem[reqIdx] <= memRline;
    end else if (strobe.writeWord) begin
      dataMem[reqIdx] <= mergedLine;
    end
  end
endmodule

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      memAck,
  output dpStrobe_t strobe,
  output logic      cpuReady,
  output logic      memReq,
  output logic      memWe
);
  ctlState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hit) begin
            cpuReady         = 1'b1;
            strobe.writeWord = cpuWe;
          end else begin
            nextState = victimDirty ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.selVictim = 1'b1;
        if (memAck) nextState = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillLine = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic [31:0]  cpuAddr,
  input  logic [31:0]  cpuWdata,
  output logic [31:0]  cpuRdata,
  output logic         cpuReady,
  output logic         memReq,
  output logic         memWe,
  output logic [31:0]  memAddr,
  output logic [127:0] memWline,
  input  logic         memAck,
  input  logic [127:0] memRline
);
  dpStrobe_t strobe;
  logic      hit;
  logic      victimDirty;

  dmc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .hit(hit), .victimDirty(victimDirty), .memAck(memAck),
    .strobe(strobe), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe)
  );

  dmc_datapath #(.ADDR_W(32), .IDX_W(IDX_W), .WORDS(4), .WORD_W(32)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRline(memRline), .hit(hit),
    .victimDirty(victimDirty), .rdWord(cpuRdata), .memAddr(memAddr),
    .memWline(memWline)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpuReq,
  input logic        cpuReady,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr
);
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpuReady |-> !memReq);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)));

  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

  assert_refill_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memWe && memAck) |=> (!cpuReq || cpuReady));

  assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[3:0] == 4'd0));
endmodule

bind dm_cache dmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpuReq(cpuReq), .cpuReady(cpuReady),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr)
);

// File: tb/dm_cache_test.sv
module dm_cache_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpuReq = 1'b0;
  logic         cpuWe = 1'b0;
  logic [31:0]  cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic [31:0]  cpuRdata;
  logic         cpuReady;
  logic         memReq;
  logic         memWe;
  logic [31:0]  memAddr;
  logic [127:0] memWline;
  logic         memAck = 1'b0;
  logic [127:0] memRline = '0;

  int checks = 0;
  int errors = 0;
  int fillCount = 0;
  int wbCount = 0;
  int waitCnt = 0;
  logic [31:0]  lastWbAddr = '0;
  logic [127:0] memModel [1024];

  always #2 clk = ~clk;

  dm_cache #(.IDX_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWline(memWline), .memAck(memAck),
    .memRline(memRline)
  );

  function automatic logic [31:0] initWord(input logic [31:0] a);
    return {16'hC0DE, 2'b00, a[13:4], a[3:2], 2'b00};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: acknowledges after a fixed wait, driven at negedge
  initial begin
    for (int b = 0; b < 1024; b++)
      for (int w = 0; w < 4; w++)
        memModel[b][w*32 +: 32] = initWord({18'd0, b[9:0], w[1:0], 2'b00});
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt == 2) begin
          memAck = 1'b1;
          if (memWe) begin
            memModel[memAddr[13:4]] = memWline;
            wbCount++;
            lastWbAddr = memAddr;
          end else begin
            memRline = memModel[memAddr[13:4]];
            fillCount++;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] addr,
                        input logic [31:0] wdata,
                        output logic [31:0] rdata, output int cyc);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    cyc = 1;
    #1;
    while (!cpuReady && cyc < 200) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rdata = cpuRdata;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  // {we, useInit, addr, data, fills, wbs}
  localparam int NV = 15;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 2'd1, 2'd0},
    {1'b0, 1'b1, 32'h0000_0008, 32'h0000_0000, 2'd0, 2'd0},
    {1'b1, 1'b0, 32'h0000_0004, 32'hDEAD_BEEF, 2'd0, 2'd0},
    {1'b0, 1'b0, 32'h0000_0004, 32'hDEAD_BEEF, 2'd0, 2'd0},
    {1'b0, 1'b1, 32'h0000_0400, 32'h0000_0000, 2'd1, 2'd1},
    {1'b0, 1'b0, 32'h0000_0004, 32'hDEAD_BEEF, 2'd1, 2'd0},
    {1'b1, 1'b0, 32'h0000_0810, 32'h1234_5678, 2'd1, 2'd0},
    {1'b0, 1'b1, 32'h0000_0814, 32'h0000_0000, 2'd0, 2'd0},
    {1'b0, 1'b0, 32'h0000_0810, 32'h1234_5678, 2'd0, 2'd0},
    {1'b1, 1'b0, 32'h0000_081C, 32'hCAFE_F00D, 2'd0, 2'd0},
    {1'b0, 1'b1, 32'h0000_0010, 32'h0000_0000, 2'd1, 2'd1},
    {1'b0, 1'b0, 32'h0000_081C, 32'hCAFE_F00D, 2'd1, 2'd0},
    {1'b0, 1'b1, 32'h0000_0818, 32'h0000_0000, 2'd0, 2'd0},
    {1'b0, 1'b1, 32'h0000_03F0, 32'h0000_0000, 2'd1, 2'd0},
    {1'b0, 1'b1, 32'h0000_03FE, 32'h0000_0000, 2'd0, 2'd0}
  };

  initial begin
    logic [31:0] rd;
    int cyc;
    int f0;
    int w0;
    repeat (3) @(negedge clk);
    check(memReq == 1'b0 && cpuReady == 1'b0, "R2 reset idle",
          {30'd0, memReq, cpuReady}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R6 R7 R8 R10 via vector walk
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      logic [31:0] exp;
      v = VEC[i];
      f0 = fillCount; w0 = wbCount;
      access(v[69], v[67:36], v[35:4], rd, cyc);
      exp = v[68] ? initWord(v[67:36]) : v[35:4];
      if (!v[69]) check(rd === exp, "R4 R1 read word", rd, exp);
      check(fillCount - f0 == int'(v[3:2]), "R6 R3 line reads",
            fillCount - f0, {30'd0, v[3:2]});
      check(wbCount - w0 == int'(v[1:0]), "R7 R5 write-backs",
            wbCount - w0, {30'd0, v[1:0]});
      if (v[3:2] == 2'd0) check(cyc == 1, "R4 hit latency", cyc, 32'd1);
      else                check(cyc > 1, "R8 miss stalls", cyc, 32'd2);
      if (i == 2)
        check(memModel[0][63:32] == initWord(32'h4), "R5 memory untouched",
              memModel[0][63:32], initWord(32'h4));
      if (i == 4)
        check(lastWbAddr == 32'h0, "R7 victim address", lastWbAddr, 32'h0);
    end

    check(lastWbAddr == 32'h0000_0810, "R7 dirty victim address",
          lastWbAddr, 32'h0000_0810);
    check(memModel[129][127:96] == 32'hCAFE_F00D, "R10 merged word written back",
          memModel[129][127:96], 32'hCAFE_F00D);
    check(memModel[129][63:32] == initWord(32'h814), "R10 other words from fill",
          memModel[129][63:32], initWord(32'h814));

    // R2: dirty line, then reset: no write-back on eviction, re-miss
    access(1'b1, 32'h0000_0020, 32'hA1B2_C3D4, rd, cyc);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    f0 = fillCount; w0 = wbCount;
    access(1'b0, 32'h0000_0420, 32'h0, rd, cyc);
    check(wbCount == w0, "R2 dirty cleared", wbCount - w0, 32'd0);
    check(fillCount - f0 == 1, "R2 valid cleared", fillCount - f0, 32'd1);
    check(rd === initWord(32'h420), "R2 read after reset", rd, initWord(32'h420));
    f0 = fillCount;
    access(1'b0, 32'h0000_0000, 32'h0, rd, cyc);
    check(fillCount - f0 == 1, "R2 old line now misses", fillCount - f0, 32'd1);
    check(rd === initWord(32'h0), "R3 refetched word", rd, initWord(32'h0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule